// File: doc/BRIEF.md
# Short Sector-Sweep Receive Address Filter

This block looks at a short sector-sweep frame of 48 bits whose frame check has already been verified elsewhere, and decides in one registered step whether the frame is meant for this station. Full 48-bit MAC addresses are not used. The frame's 16-bit addressing field holds two compact 8-bit identifiers, one for the receiver and one for the transmitter. During an initiator sweep sent to a single peer, the frame also carries a 10-bit scrambled network hash. The expected value of that hash depends on the 4-bit seed that arrives with the frame.

Configuration supplies the following:
- the station's role (station or access point / PCP),
- its own 8-bit identifier,
- the network's 8-bit BSS identifier,
- a table of expected hashes, one entry per seed,
- a 256-bit map of associated transmitter identifiers.

The receiver identifier is always checked against the station's own identifier. The hash check applies only during initiator sweeps to a single peer. The transmitter check is optional. A 2-bit reason code reports the first check that failed.

Top module: `ssw_addr_filter`

## Requirements
- R1: After reset, dec_valid, dec_accept and dec_reason are 0. Every hash-table entry is 0 and the associated-identifier map is empty.
- R2: dec_valid is 1 exactly in the cycle after a cycle with frm_valid = 1, and 0 otherwise. The decision uses the frame, seed, flag and configuration sampled in the strobe cycle.
- R3: When frm_iss_unicast = 1, frame bits [15:6] must equal the hash-table entry selected by frm_seed. A mismatch gives reason 1 (hash mismatch).
- R4: When frm_iss_unicast = 0, the hash check is skipped. Frame bits [16:6] have no effect on the decision.
- R5: The receiver identifier in frame bits [45:38] must equal the station's own identifier. A mismatch gives reason 2 (receiver mismatch).
- R6: The station's own identifier is cfg_bss_aid when cfg_is_ap = 1, and cfg_own_aid otherwise.
- R7: When cfg_ta_chk_en = 1, the map bit indexed by the transmitter identifier in frame bits [37:30] must be 1, otherwise the reason is 3 (unknown transmitter). When cfg_ta_chk_en = 0, this check has no effect.
- R8: The checks are prioritised: hash, then receiver, then transmitter. The reported reason is that of the first failing check.
- R9: dec_accept is 1 exactly when dec_valid = 1 and dec_reason = 0 (all enabled checks passed).
- R10: A write with hash_we = 1 replaces entry hash_addr with hash_wdata. A write with map_we = 1 sets or clears map bit map_addr to map_wdata. Writes affect frames strobed in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_is_ap | input | 1 | Station acts as access point / PCP |
| cfg_own_aid | input | 8 | Low 8 bits of the station's assigned identifier |
| cfg_bss_aid | input | 8 | Network BSS identifier |
| cfg_ta_chk_en | input | 1 | Enable the transmitter-association check |
| hash_we | input | 1 | Hash-table write enable |
| hash_addr | input | 4 | Hash-table entry (seed) to write |
| hash_wdata | input | 10 | Expected hash value |
| map_we | input | 1 | Association-map write enable |
| map_addr | input | 8 | Identifier whose map bit is written |
| map_wdata | input | 1 | New map bit |
| frm_valid | input | 1 | Frame strobe |
| frm_data | input | 48 | Frame: [47:46] type, [45:38] receiver id, [37:30] transmitter id, [29:19] countdown, [18:17] chain, [16:6] feedback / hash in [15:6], [5] direction, [4] reserved, [3:0] FCS |
| frm_seed | input | 4 | Scrambler seed sampled with the strobe |
| frm_iss_unicast | input | 1 | Frame belongs to an initiator sweep to a single peer |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame addressed to this station |
| dec_reason | output | 2 | 0 accept, 1 hash mismatch, 2 receiver mismatch, 3 unknown transmitter |

## Verification
The block's state consists of the hash table, the association map and the decision register. Each of them is visible on the next decision after the state is used. A stale or wrong hash entry, for example, shows up as reason 1 on the first frame that uses that seed, one cycle after the strobe. A wrong map bit shows up as reason 3 on the first frame from that transmitter while the check is enabled. A wrong priority or a leaking feedback field changes the reason code of a frame that fails several checks at once. The bench therefore sends such frames and also frames that fail exactly one check.

// File: rtl/ssw_filt_pkg.sv
package ssw_filt_pkg;
  localparam int FRAME_W  = 48;
  localparam int ID_W     = 8;
  localparam int HASH_W   = 10;
  localparam int N_SEEDS  = 16;
  // Field widths, least significant field first (frame order is MSB first).
  localparam int FCS_W    = 4;
  localparam int RSV_W    = 1;
  localparam int DIR_W    = 1;
  localparam int FB_W     = 11;
  localparam int CHAIN_W  = 2;
  localparam int CDOWN_W  = 11;
  localparam int ADDR_W   = 2 * ID_W;
  localparam int FB_LSB   = FCS_W + RSV_W + DIR_W;
  localparam int ADDR_LSB = FB_LSB + FB_W + CHAIN_W + CDOWN_W;
  localparam int TX_LSB   = ADDR_LSB;
  localparam int RX_LSB   = ADDR_LSB + ID_W;

  typedef enum logic [1:0] {
    RSN_ACCEPT  = 2'd0,
    RSN_HASH    = 2'd1,
    RSN_RX_ID   = 2'd2,
    RSN_TX_UNKN = 2'd3
  } reason_e;
endpackage

// File: rtl/ssw_hash_table.sv
module ssw_hash_table #(
  parameter int N_SEEDS = 16,
  parameter int HASH_W  = 10,
  localparam int SEED_W = $clog2(N_SEEDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEED_W-1:0] waddr,
  input  logic [HASH_W-1:0] wdata,
  input  logic [SEED_W-1:0] raddr,
  output logic [HASH_W-1:0] rdata
);
  logic [HASH_W-1:0] tbl_q [N_SEEDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SEEDS; i++) tbl_q[i] <= '0;
    end else if (we) begin
      tbl_q[waddr] <= wdata;
    end
  end

  assign rdata = tbl_q[raddr];

  // R1: reset leaves the selected entry at zero
  a_r1_table_cleared: assert property (@(posedge clk) rst |=> (tbl_q[0] == '0));
  // R10: a write lands in the addressed entry
  a_r10_table_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (tbl_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ssw_assoc_map.sv
module ssw_assoc_map #(
  parameter int ID_W   = 8,
  localparam int N_IDS = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [ID_W-1:0] waddr,
  input  logic            wdata,
  input  logic [ID_W-1:0] raddr,
  output logic            known
);
  logic [N_IDS-1:0] map_q;

  for (genvar g = 0; g < N_IDS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                  map_q[g] <= 1'b0;
      else if (we && (waddr == ID_W'(g)))       map_q[g] <= wdata;
    end
  end

  assign known = map_q[raddr];

  // R1: map empty after reset
  a_r1_map_cleared: assert property (@(posedge clk) rst |=> (map_q == '0));
  // R10: only the addressed bit may change on a write
  a_r10_map_single_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(map_q ^ $past(map_q)) <= 1));
endmodule

// File: rtl/ssw_addr_decide.sv
module ssw_addr_decide
  import ssw_filt_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int HASH_W = 10
) (
  input  logic              hash_chk,
  input  logic [HASH_W-1:0] rx_hash,
  input  logic [HASH_W-1:0] exp_hash,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [ID_W-1:0]   own_id,
  input  logic              tx_chk,
  input  logic              tx_known,
  output reason_e           reason
);
  always_comb begin
    if (hash_chk && (rx_hash != exp_hash))  reason = RSN_HASH;
    else if (rx_id != own_id)               reason = RSN_RX_ID;
    else if (tx_chk && !tx_known)           reason = RSN_TX_UNKN;
    else                                    reason = RSN_ACCEPT;
  end
endmodule

// File: rtl/ssw_addr_filter.sv
module ssw_addr_filter
  import ssw_filt_pkg::*;
#(
  parameter int N_SEEDS = ssw_filt_pkg::N_SEEDS,
  parameter int HASH_W  = ssw_filt_pkg::HASH_W,
  localparam int SEED_W = $clog2(N_SEEDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_is_ap,
  input  logic [ID_W-1:0]    cfg_own_aid,
  input  logic [ID_W-1:0]    cfg_bss_aid,
  input  logic               cfg_ta_chk_en,
  input  logic               hash_we,
  input  logic [SEED_W-1:0]  hash_addr,
  input  logic [HASH_W-1:0]  hash_wdata,
  input  logic               map_we,
  input  logic [ID_W-1:0]    map_addr,
  input  logic               map_wdata,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  input  logic [SEED_W-1:0]  frm_seed,
  input  logic               frm_iss_unicast,
  output logic               dec_valid,
  output logic               dec_accept,
  output logic [1:0]         dec_reason
);
  logic [ID_W-1:0]   rx_id, tx_id, own_id;
  logic [HASH_W-1:0] rx_hash, exp_hash;
  logic              tx_known;
  reason_e           reason;

  assign rx_id   = frm_data[RX_LSB +: ID_W];
  assign tx_id   = frm_data[TX_LSB +: ID_W];
  assign rx_hash = frm_data[FB_LSB +: HASH_W];
  assign own_id  = cfg_is_ap ? cfg_bss_aid : cfg_own_aid;

  logic unused_frame_bits;
  assign unused_frame_bits = ^{frm_data[FRAME_W-1:ADDR_LSB+ADDR_W],
                               frm_data[ADDR_LSB-1:FB_LSB+HASH_W],
                               frm_data[FB_LSB-1:0]};

  ssw_hash_table #(.N_SEEDS(N_SEEDS), .HASH_W(HASH_W)) hash_tbl_i (
    .clk(clk), .rst(rst), .we(hash_we), .waddr(hash_addr), .wdata(hash_wdata),
    .raddr(frm_seed), .rdata(exp_hash)
  );

  ssw_assoc_map #(.ID_W(ID_W)) assoc_map_i (
    .clk(clk), .rst(rst), .we(map_we), .waddr(map_addr), .wdata(map_wdata),
    .raddr(tx_id), .known(tx_known)
  );

  ssw_addr_decide #(.ID_W(ID_W), .HASH_W(HASH_W)) decide_i (
    .hash_chk(frm_iss_unicast), .rx_hash(rx_hash), .exp_hash(exp_hash),
    .rx_id(rx_id), .own_id(own_id), .tx_chk(cfg_ta_chk_en),
    .tx_known(tx_known), .reason(reason)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= 2'd0;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid && (reason == RSN_ACCEPT);
      dec_reason <= frm_valid ? reason : 2'd0;
    end
  end

  // R2: decision follows the strobe by exactly one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_valid);
  // R4: no hash failure outside an initiator unicast sweep
  a_r4_hash_skipped: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_iss_unicast) |=> (dec_reason != 2'd1));
  // R7: disabled transmitter check never rejects
  a_r7_tx_disabled: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !cfg_ta_chk_en) |=> (dec_reason != 2'd3));
  // R8: receiver mismatch outranks the transmitter check
  a_r8_rx_before_tx: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_iss_unicast && (rx_id != own_id)) |=> (dec_reason == 2'd2));
  // R9: accept only on a valid decision with reason zero
  a_r9_accept_consistent: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> (dec_valid && (dec_reason == 2'd0)));
endmodule

// File: tb/ssw_addr_filter_tb.sv
module ssw_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_is_ap = 1'b0, cfg_ta_chk_en = 1'b0;
  logic [7:0]  cfg_own_aid = 8'h2A, cfg_bss_aid = 8'hC5;
  logic        hash_we = 1'b0, map_we = 1'b0, map_wdata = 1'b0;
  logic [3:0]  hash_addr = '0;
  logic [9:0]  hash_wdata = '0;
  logic [7:0]  map_addr = '0;
  logic        frm_valid = 1'b0, frm_iss_unicast = 1'b0;
  logic [47:0] frm_data = '0;
  logic [3:0]  frm_seed = '0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_reason;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssw_addr_filter dut_i (
    .clk(clk), .rst(rst), .cfg_is_ap(cfg_is_ap), .cfg_own_aid(cfg_own_aid),
    .cfg_bss_aid(cfg_bss_aid), .cfg_ta_chk_en(cfg_ta_chk_en),
    .hash_we(hash_we), .hash_addr(hash_addr), .hash_wdata(hash_wdata),
    .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_seed(frm_seed),
    .frm_iss_unicast(frm_iss_unicast), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  function automatic logic [9:0] seed_hash(input logic [3:0] s);
    return 10'((s * 10'h05B) + 10'h013);
  endfunction

  // Vector: {iss, seed, rx, tx, hash_ok, is_ap, tx_en, exp_reason}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 4'd3,  8'h2A, 8'h11, 1'b1, 1'b0, 1'b1, 2'd0},  // R9 all pass
    {1'b1, 4'd7,  8'h2A, 8'h11, 1'b0, 1'b0, 1'b1, 2'd1},  // R3
    {1'b1, 4'd7,  8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 2'd1},  // R8 hash first
    {1'b0, 4'd7,  8'h2A, 8'h11, 1'b0, 1'b0, 1'b1, 2'd0},  // R4
    {1'b0, 4'd0,  8'h2B, 8'h11, 1'b0, 1'b0, 1'b1, 2'd2},  // R5
    {1'b1, 4'd15, 8'hC5, 8'h77, 1'b1, 1'b1, 1'b1, 2'd0},  // R6 AP id
    {1'b1, 4'd15, 8'h2A, 8'h77, 1'b1, 1'b1, 1'b1, 2'd2},  // R6 station id refused
    {1'b1, 4'd0,  8'h2A, 8'h12, 1'b1, 1'b0, 1'b1, 2'd3},  // R7
    {1'b1, 4'd0,  8'h2A, 8'h12, 1'b1, 1'b0, 1'b0, 2'd0},  // R7 disabled
    {1'b1, 4'd9,  8'h00, 8'h12, 1'b1, 1'b0, 1'b1, 2'd2},  // R8 rx before tx
    {1'b0, 4'd5,  8'h2A, 8'hC5, 1'b1, 1'b0, 1'b1, 2'd0},  // R4 good hash ignored too
    {1'b1, 4'd12, 8'hC5, 8'h2A, 1'b1, 1'b1, 1'b1, 2'd3}   // R7 unknown tx as AP
  };

  task automatic check(input string req, input logic [1:0] exp_r);
    logic [3:0] act, expv;
    act  = {dec_valid, dec_accept, dec_reason};
    expv = {1'b1, (exp_r == 2'd0), exp_r};
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: {valid,accept,reason} actual=%b expected=%b", req, act, expv);
    end
  endtask

  // Strobe one frame at a negedge; result is sampled at the following negedge.
  task automatic send(input logic iss, input logic [3:0] seed, input logic [7:0] rx,
                      input logic [7:0] tx, input logic [9:0] hash, input logic [10:0] cd);
    @(negedge clk);
    frm_valid       = 1'b1;
    frm_iss_unicast = iss;
    frm_seed        = seed;
    frm_data        = {2'b01, rx, tx, cd, 2'b10, 1'b1, hash, 1'b0, 1'b1, 4'hA};
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wr_hash(input logic [3:0] a, input logic [9:0] d);
    @(negedge clk); hash_we = 1'b1; hash_addr = a; hash_wdata = d;
    @(negedge clk); hash_we = 1'b0;
  endtask

  task automatic wr_map(input logic [7:0] a, input logic d);
    @(negedge clk); map_we = 1'b1; map_addr = a; map_wdata = d;
    @(negedge clk); map_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle after reset
    n_checks++;
    if ({dec_valid, dec_accept, dec_reason} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 idle: actual=%b expected=0000", {dec_valid, dec_accept, dec_reason});
    end
    // R1: empty table and map: hash 0 matches, tx unknown
    cfg_ta_chk_en = 1'b1;
    send(1'b1, 4'd4, 8'h2A, 8'h11, 10'h000, 11'h123);
    check("R1 cleared state", 2'd3);
    // R2: no decision without a strobe
    @(negedge clk);
    n_checks++;
    if (dec_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle cycle: actual=%b expected=0", dec_valid);
    end

    for (int s = 0; s < 16; s++) wr_hash(4'(s), seed_hash(4'(s)));
    wr_map(8'h11, 1'b1);
    wr_map(8'h77, 1'b1);
    wr_map(8'hC5, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      logic [9:0]  h;
      v = VEC[i];
      cfg_is_ap     = v[3];
      cfg_ta_chk_en = v[2];
      h = v[4] ? seed_hash(v[24:21]) : (seed_hash(v[24:21]) ^ 10'h155);
      send(v[25], v[24:21], v[20:13], v[12:5], h, 11'(i * 37));
      check($sformatf("vector %0d (R3 R4 R5 R6 R7 R8 R9)", i), v[1:0]);
    end

    // R10: rewrite seed 3 entry; old value now fails, new passes
    cfg_is_ap = 1'b0; cfg_ta_chk_en = 1'b1;
    wr_hash(4'd3, 10'h2F0);
    send(1'b1, 4'd3, 8'h2A, 8'h11, seed_hash(4'd3), 11'h001);
    check("R10 old hash rejected", 2'd1);
    send(1'b1, 4'd3, 8'h2A, 8'h11, 10'h2F0, 11'h002);
    check("R10 new hash accepted", 2'd0);
    // R10: clearing a map bit
    wr_map(8'h11, 1'b0);
    send(1'b0, 4'd0, 8'h2A, 8'h11, 10'h000, 11'h003);
    check("R10 cleared map bit", 2'd3);

    // R2: back-to-back strobes, each decided one cycle later
    @(negedge clk);
    frm_valid = 1'b1; frm_iss_unicast = 1'b0;
    frm_data = {2'b00, 8'h2A, 8'h77, 11'h0, 2'b0, 11'h7FF, 1'b0, 1'b0, 4'h0};
    @(negedge clk);
    check("R2 first of pair", 2'd0);
    frm_data = {2'b00, 8'h2C, 8'h77, 11'h0, 2'b0, 11'h7FF, 1'b0, 1'b0, 4'h0};
    @(negedge clk);
    frm_valid = 1'b0;
    check("R2 second of pair", 2'd2);
    @(negedge clk);
    n_checks++;
    if (dec_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 drop after pair: actual=%b expected=0", dec_valid);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule